// File: doc/BRIEF.md
# Index-to-Index Span Counter with Zero Codification

This block measures the signed number of quadrature count steps between successive index pulses of an incremental encoder. A decoder upstream supplies a one-cycle count enable together with a direction bit. On every rising edge of the index input, the accumulated span is captured into an update register and a one-cycle load pulse is raised. The span counter then starts again from zero.

A zero-codification command arms a reference search. The first index edge after the command, or after reset, only opens a measurement window. The span measured at the next distinct index edge becomes the reference value, and the reference-ok level rises. If a window runs past the signed range of the counter, the counter saturates and a one-cycle overflow pulse is issued. A reference captured from such a window is refused, and an established reference is marked not ok. The pulses are meant for a status bank elsewhere in the chip.

Top module: `span_ref_counter`

## Requirements
- R1: After reset, `upd_value` and `ref_value` are 0, and `ref_ok`, `ref_set_p`, `upd_load_p` and `span_ovf_p` are all low.
- R2: An index edge is the cycle in which `index_in` is 1 after having been 0 in the previous cycle. A high level held for any number of cycles gives exactly one `upd_load_p` pulse.
- R3: Each cycle with `step_en`=1 changes the span by +1 when `step_dir`=1 and by -1 when `step_dir`=0. On each index edge without `zc_start`, the span is written to `upd_value` (two's complement) and `upd_load_p` is high for the cycle after that edge.
- R4: A step taken in the same cycle as an index edge counts in the captured span. The next window starts from zero.
- R5: The span is limited to -2^(SPAN_W-1) .. 2^(SPAN_W-1)-1. A step past a limit leaves the counter at that limit until the next restart.
- R6: `span_ovf_p` is high for one cycle after the first step in a window that would leave the range. It is raised at most once per window.
- R7: After reset or `zc_start`, `ref_ok` stays low through the first index edge. At the second index edge, a clean span is written to `ref_value`, `ref_ok` rises and `ref_set_p` pulses for one cycle.
- R8: When an index edge ends a window that overflowed, `ref_value` is not loaded and `ref_ok` is low afterwards. The next clean window loads the reference.
- R9: While the reference is established, later clean index edges update only `upd_value`. `ref_value`, `ref_ok`=1 and `ref_set_p`=0 are kept.
- R10: `zc_start` clears `ref_ok` and restarts the span counter. An index edge in the same cycle loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | One count step this cycle |
| step_dir | input | 1 | Step direction, 1 up, 0 down |
| index_in | input | 1 | Index level from the encoder |
| zc_start | input | 1 | Start zero codification |
| ref_value | output | SPAN_W | Reference span, two's complement |
| upd_value | output | SPAN_W | Most recent span, two's complement |
| ref_ok | output | 1 | Reference value is valid |
| ref_set_p | output | 1 | Pulse: reference just loaded |
| upd_load_p | output | 1 | Pulse: update register just loaded |
| span_ovf_p | output | 1 | Pulse: span left its range |

## Verification
The bench uses a 6-bit counter and sweeps window lengths from -40 to +40, which covers both saturation limits. The last step of every window shares its cycle with the index edge. A design that drops the coincident step, or carries it into the new window, would report spans off by one or fail to show a zero span on the following empty window. A design that wraps instead of saturating would give wrong captured values and repeated overflow pulses. A design that accepts a reference from an overflowed window would raise `ref_ok`. Further sequences hold the index high over many cycles, overflow a window while a reference is established, and issue the zero-codification command in the same cycle as an index edge. These catch designs that retrigger on a level, keep a stale valid flag, or treat the first index edge as a reference.

// File: rtl/span_ref_pkg.sv
`timescale 1ns/1ps
package span_ref_pkg;
    typedef enum logic [1:0] {
        ZC_ARM  = 2'd0,
        ZC_ONE  = 2'd1,
        ZC_LOCK = 2'd2
    } zc_state_e;
endpackage

// File: rtl/span_idx_edge.sv
`timescale 1ns/1ps
module span_idx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic idx_in,
    output logic idx_rise
);
    typedef struct packed {
        logic lvl;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d     = edge_q;
        edge_d.lvl = idx_in;
        idx_rise   = idx_in & ~edge_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    // a rise can never be followed by another rise on the next cycle
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_rise |=> !idx_rise);
endmodule

// File: rtl/span_accum.sv
`timescale 1ns/1ps
module span_accum #(
    parameter int SPAN_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic                     step_dir,
    input  logic                     restart,
    output logic signed [SPAN_W-1:0] span_val,
    output logic                     span_bad,
    output logic                     ovf_p
);
    localparam logic signed [SPAN_W-1:0] SPAN_MAX = {1'b0, {(SPAN_W-1){1'b1}}};
    localparam logic signed [SPAN_W-1:0] SPAN_MIN = {1'b1, {(SPAN_W-1){1'b0}}};
    localparam logic signed [SPAN_W-1:0] SPAN_ONE = {{(SPAN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic signed [SPAN_W-1:0] cnt;
        logic                     win_ovf;
        logic                     ovf_p;
    } acc_t;

    acc_t acc_d, acc_q;
    logic signed [SPAN_W-1:0] stepped;
    logic                     step_ovf;

    always_comb begin
        stepped  = acc_q.cnt;
        step_ovf = 1'b0;
        if (step_en) begin
            if (step_dir) begin
                if (acc_q.cnt == SPAN_MAX) step_ovf = 1'b1;
                else                       stepped  = acc_q.cnt + SPAN_ONE;
            end else begin
                if (acc_q.cnt == SPAN_MIN) step_ovf = 1'b1;
                else                       stepped  = acc_q.cnt - SPAN_ONE;
            end
        end

        span_val = stepped;
        span_bad = acc_q.win_ovf | step_ovf;
        ovf_p    = acc_q.ovf_p;

        acc_d       = acc_q;
        acc_d.ovf_p = step_ovf & ~acc_q.win_ovf;
        if (restart) begin
            acc_d.cnt     = '0;
            acc_d.win_ovf = 1'b0;
        end else begin
            acc_d.cnt     = stepped;
            acc_d.win_ovf = acc_q.win_ovf | step_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    p_hold_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.cnt == SPAN_MAX && step_en && step_dir && !restart) |=> acc_q.cnt == SPAN_MAX);

    p_hold_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.cnt == SPAN_MIN && step_en && !step_dir && !restart) |=> acc_q.cnt == SPAN_MIN);

    p_ovf_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_p |=> !ovf_p);

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> acc_q.cnt == '0 && !acc_q.win_ovf);
endmodule

// File: rtl/span_ref_capture.sv
`timescale 1ns/1ps
module span_ref_capture
    import span_ref_pkg::*;
#(
    parameter int SPAN_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     idx_rise,
    input  logic                     zc_start,
    input  logic signed [SPAN_W-1:0] span_val,
    input  logic                     span_bad,
    output logic [SPAN_W-1:0]        ref_value,
    output logic [SPAN_W-1:0]        upd_value,
    output logic                     ref_ok,
    output logic                     ref_set_p,
    output logic                     upd_load_p
);
    typedef struct packed {
        zc_state_e          st;
        logic [SPAN_W-1:0]  ref_v;
        logic [SPAN_W-1:0]  upd_v;
        logic               ok;
        logic               ref_p;
        logic               upd_p;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.ref_p = 1'b0;
        cap_d.upd_p = 1'b0;
        if (zc_start) begin
            cap_d.st = ZC_ARM;
            cap_d.ok = 1'b0;
        end else if (idx_rise) begin
            cap_d.upd_v = span_val;
            cap_d.upd_p = 1'b1;
            unique case (cap_q.st)
                ZC_ARM: cap_d.st = ZC_ONE;
                ZC_ONE: begin
                    if (!span_bad) begin
                        cap_d.ref_v = span_val;
                        cap_d.ok    = 1'b1;
                        cap_d.ref_p = 1'b1;
                        cap_d.st    = ZC_LOCK;
                    end
                end
                ZC_LOCK: begin
                    if (span_bad) begin
                        cap_d.ok = 1'b0;
                        cap_d.st = ZC_ONE;
                    end
                end
                default: cap_d.st = ZC_ARM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q    <= '0;
            cap_q.st <= ZC_ARM;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign ref_value  = cap_q.ref_v;
    assign upd_value  = cap_q.upd_v;
    assign ref_ok     = cap_q.ok;
    assign ref_set_p  = cap_q.ref_p;
    assign upd_load_p = cap_q.upd_p;

    p_load_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_rise && !zc_start) |=> upd_load_p);

    p_no_ref_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.st == ZC_ARM) |=> !ref_ok);

    p_set_means_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_set_p |-> ref_ok);

    p_bad_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_rise && span_bad) |=> !ref_ok);

    p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.st == ZC_LOCK && !zc_start) |=> $stable(ref_value));

    p_zc_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zc_start |=> (!ref_ok && !upd_load_p));
endmodule

// File: rtl/span_ref_counter.sv
`timescale 1ns/1ps
module span_ref_counter #(
    parameter int SPAN_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              step_dir,
    input  logic              index_in,
    input  logic              zc_start,
    output logic [SPAN_W-1:0] ref_value,
    output logic [SPAN_W-1:0] upd_value,
    output logic              ref_ok,
    output logic              ref_set_p,
    output logic              upd_load_p,
    output logic              span_ovf_p
);
    logic                     idx_rise;
    logic                     restart;
    logic signed [SPAN_W-1:0] span_val;
    logic                     span_bad;

    assign restart = idx_rise | zc_start;

    span_idx_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_in   (index_in),
        .idx_rise (idx_rise)
    );

    span_accum #(.SPAN_W(SPAN_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .step_dir (step_dir),
        .restart  (restart),
        .span_val (span_val),
        .span_bad (span_bad),
        .ovf_p    (span_ovf_p)
    );

    span_ref_capture #(.SPAN_W(SPAN_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_rise   (idx_rise),
        .zc_start   (zc_start),
        .span_val   (span_val),
        .span_bad   (span_bad),
        .ref_value  (ref_value),
        .upd_value  (upd_value),
        .ref_ok     (ref_ok),
        .ref_set_p  (ref_set_p),
        .upd_load_p (upd_load_p)
    );

    p_ovf_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        span_ovf_p |=> !span_ovf_p);
endmodule

// File: tb/span_ref_counter_test.sv
`timescale 1ns/1ps
module span_ref_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 6;
    localparam int SMAX = 31;
    localparam int SMIN = -32;

    logic         clk = 1'b0;
    logic         rst_n, step_en, step_dir, index_in, zc_start;
    logic [W-1:0] ref_value, upd_value;
    logic         ref_ok, ref_set_p, upd_load_p, span_ovf_p;

    int  checks = 0;
    int  errors = 0;
    int  ovf_cnt = 0;
    int  load_cnt = 0;
    bit  done = 1'b0;

    span_ref_counter #(.SPAN_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_dir(step_dir),
        .index_in(index_in), .zc_start(zc_start), .ref_value(ref_value),
        .upd_value(upd_value), .ref_ok(ref_ok), .ref_set_p(ref_set_p),
        .upd_load_p(upd_load_p), .span_ovf_p(span_ovf_p)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input logic en, input logic dir, input logic idx, input logic zc);
        step_en  = en;
        step_dir = dir;
        index_in = idx;
        zc_start = zc;
        @(posedge clk);
        @(negedge clk);
        if (span_ovf_p) ovf_cnt++;
        if (upd_load_p) load_cnt++;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp(input int n);
        if (n > SMAX) return SMAX;
        if (n < SMIN) return SMIN;
        return n;
    endfunction

    task automatic run_window(input int n, input bit coincide,
                              output int upd, output int ok, output int rset, output int ld);
        int   mag;
        int   pre;
        logic d;
        mag = (n < 0) ? -n : n;
        d   = (n > 0);
        pre = (coincide && mag > 0) ? mag - 1 : mag;
        for (int i = 0; i < pre; i++) tick(1'b1, d, 1'b0, 1'b0);
        if (coincide && mag > 0) tick(1'b1, d, 1'b1, 1'b0);
        else                     tick(1'b0, 1'b0, 1'b1, 1'b0);
        upd  = int'($signed(upd_value));
        ok   = int'(ref_ok);
        rset = int'(ref_set_p);
        ld   = int'(upd_load_p);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int  u, ok, rs, ld;
        bit  beyond;
        rst_n = 1'b0; step_en = 1'b0; step_dir = 1'b0; index_in = 1'b0; zc_start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 upd_value", int'(upd_value), 0);
        chk("R1 ref_value", int'(ref_value), 0);
        chk("R1 ref_ok", int'(ref_ok), 0);
        chk("R1 pulses", int'({ref_set_p, upd_load_p, span_ovf_p}), 0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0, 1'b0);

        // R2 long index level gives one load
        load_cnt = 0;
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 single load", load_cnt, 1);

        // sweep over spans through both limits (R3 R4 R5 R6 R7 R8 R9)
        for (int n = -40; n <= 40; n++) begin
            beyond = (n > SMAX) || (n < SMIN);
            tick(1'b0, 1'b0, 1'b0, 1'b1);
            chk("R10 zc clears ref_ok", int'(ref_ok), 0);
            run_window(0, 1'b0, u, ok, rs, ld);
            chk("R7 first edge no ref", ok, 0);
            chk("R3 load pulse", ld, 1);
            ovf_cnt = 0;
            run_window(n, 1'b1, u, ok, rs, ld);
            chk("R5 captured span", u, clamp(n));
            chk("R6 overflow pulses", ovf_cnt, beyond ? 1 : 0);
            chk("R8 ref_ok after window", ok, beyond ? 0 : 1);
            chk("R7 ref_set pulse", rs, beyond ? 0 : 1);
            run_window(0, 1'b0, u, ok, rs, ld);
            chk("R4 restart after coincident step", u, 0);
            chk("R9 ref_ok kept", ok, 1);
            chk("R9 ref_value", int'($signed(ref_value)), beyond ? 0 : n);
        end

        // R9 and R8 while established
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        run_window(0, 1'b0, u, ok, rs, ld);
        run_window(4, 1'b0, u, ok, rs, ld);
        chk("R7 ref loaded", int'($signed(ref_value)), 4);
        run_window(-9, 1'b0, u, ok, rs, ld);
        chk("R9 upd only", u, -9);
        chk("R9 ref held", int'($signed(ref_value)), 4);
        chk("R9 ok held", ok, 1);
        chk("R9 no set pulse", rs, 0);
        run_window(40, 1'b0, u, ok, rs, ld);
        chk("R8 ok dropped", ok, 0);
        chk("R8 ref not loaded", int'($signed(ref_value)), 4);
        run_window(7, 1'b0, u, ok, rs, ld);
        chk("R8 reload ok", ok, 1);
        chk("R8 reload value", int'($signed(ref_value)), 7);

        // R10 zc with same-cycle index edge
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 no load with zc", int'(upd_load_p), 0);
        chk("R10 ok cleared", int'(ref_ok), 0);
        tick(1'b0, 1'b0, 1'b0, 1'b0);
        run_window(3, 1'b0, u, ok, rs, ld);
        chk("R10 counter restarted", u, 3);
        chk("R10 first edge after zc", ok, 0);
        run_window(-2, 1'b0, u, ok, rs, ld);
        chk("R10 ref after second edge", ok, 1);
        chk("R10 ref value", int'($signed(ref_value)), -2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule